// File: doc/BRIEF.md
# Sampling Converter Host Port Controller

This block is the digital side of a 12-bit sampling converter's microprocessor port. The host pulls the active-low chip-select and read strobes low together. That one action puts data on the bus, and it also starts the next conversion unless the byte-enable input is high. An active-low busy flag stays low for a fixed number of clock cycles. At the end of that count the converter core, modelled here by a counter, drops a sample taken from an input port into the result latch.

A mode input picks how a read relates to the conversion it starts. In slow-memory mode the host holds its read open. The bus shows the live latch, so the previous result is visible while busy is low and the new result appears as busy rises. In ROM mode the bus freezes the result held at the strobe's falling edge for the whole read. Every read therefore returns the previous conversion, and the host never waits.

The result is right-justified. A 12-bit host reads it in one access with byte-enable low. An 8-bit host reads the low byte first, then issues a second read with byte-enable high to get the four MSBs on the low nibble lanes; that second read starts no conversion. The bus is modelled as a data value plus an output enable, with no tri-state driver.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset busy_no_o is 1, data_oe_o is 0 and the result latch holds zero, so the first read shows 0x000.
- R2: A falling edge of the combined strobe (cs_ni_i and rd_ni_i both low) with hben_i low, while busy_no_o is 1, drives busy_no_o low from the next clock cycle for exactly CONV_CYCLES cycles.
- R3: Strobe edges that arrive while busy_no_o is low start nothing: the running conversion ends on schedule and no new one follows.
- R4: In the clock edge where busy_no_o returns to 1, the result latch loads sample_i, so the new value is readable as soon as busy_no_o is high.
- R5: data_oe_o is 1 exactly while cs_ni_i and rd_ni_i are both low; it is 0 when only one of them is low.
- R6: With hben_i low, data_o[11:0] carries the full result, right-justified, with the LSB on bit 0.
- R7: With hben_i high, data_o[11:8] and data_o[3:0] both carry the result's four MSBs, data_o[7:4] is zero, and the read starts no conversion.
- R8: In slow-memory mode (rom_mode_i = 0), during a single read the bus shows the previous result while busy_no_o is low and the new result from the cycle in which busy_no_o is high.
- R9: In ROM mode (rom_mode_i = 1), a read shows the result held at its strobe's falling edge for its whole duration, even when a conversion finishes during the read.
- R10: A strobe held low past the end of a conversion does not start another one; a start needs a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni_i | input | 1 | Chip select, active low |
| rd_ni_i | input | 1 | Read strobe, active low |
| hben_i | input | 1 | Byte enable: 1 selects the high-nibble view and blocks a start |
| rom_mode_i | input | 1 | 0 = slow-memory mode, 1 = ROM mode |
| sample_i | input | DATA_W | Converter core sample, loaded when a conversion ends |
| data_o | output | DATA_W | Bus data value |
| data_oe_o | output | 1 | Bus output enable |
| busy_no_o | output | 1 | Busy flag, low while a conversion runs |

## Verification
The bench pulses the strobe off and on again in the middle of a conversion. A design that restarted on such an edge would stretch busy past its fixed length, and the bench would see busy still low in the cycle it expects high. It holds a read open across the end of a conversion in both modes. A slow-memory design that froze the bus would never show the new result, and a ROM-mode design that followed the latch would show it too early. It also keeps the strobe low after busy rises, where a level-triggered start would drop busy a second time. Finally it checks that the high-nibble read leaves busy high and that the nibble lands on the right lanes with zeros between.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_e;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_SNAP = 1'b1
  } bus_src_e;
endpackage

// File: rtl/adc_strobe_edge.sv
module adc_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni_i,
  input  logic rd_ni_i,
  input  logic hben_i,
  input  logic idle_i,
  output logic strobe_o,
  output logic strobe_q_o,
  output logic fall_o,
  output logic start_o
);
  logic strobe_q;

  assign strobe_o = ~cs_ni_i & ~rd_ni_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_o;
  end

  assign strobe_q_o = strobe_q;
  assign fall_o     = strobe_o & ~strobe_q;
  // high-nibble read and strobes during a conversion never start one
  assign start_o    = fall_o & ~hben_i & idle_i;
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o
);
  import adc_bus_pkg::*;

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  conv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CONV;
            cnt_q   <= CNT_LAST;
          end
        end
        ST_CONV: begin
          if (cnt_q == '0) begin
            state_q  <= ST_IDLE;
            result_q <= sample_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_CONV);
  assign result_o = result_q;
endmodule

// File: rtl/adc_bus_mux.sv
module adc_bus_mux #(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              strobe_q_i,
  input  logic              fall_i,
  input  logic              hben_i,
  input  logic              rom_mode_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  import adc_bus_pkg::*;

  localparam int HI_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] word;
  bus_src_e          src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (fall_i) snap_q <= result_i;
  end

  // ROM mode: freeze what the read saw at its falling edge
  assign src  = (rom_mode_i && strobe_q_i) ? SRC_SNAP : SRC_LIVE;
  assign word = (src == SRC_SNAP) ? snap_q : result_i;

  assign data_o[DATA_W-1:BYTE_W] = word[DATA_W-1:BYTE_W];

  for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
    if (i < HI_W) begin : g_dual
      assign data_o[i] = hben_i ? word[BYTE_W+i] : word[i];
    end else begin : g_low
      assign data_o[i] = hben_i ? 1'b0 : word[i];
    end
  end

  assign data_oe_o = strobe_i;
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni_i,
  input  logic              rd_ni_i,
  input  logic              hben_i,
  input  logic              rom_mode_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_no_o
);
  logic strobe, strobe_q, fall, start, busy;
  logic [DATA_W-1:0] result;

  adc_strobe_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni_i    (cs_ni_i),
    .rd_ni_i    (rd_ni_i),
    .hben_i     (hben_i),
    .idle_i     (~busy),
    .strobe_o   (strobe),
    .strobe_q_o (strobe_q),
    .fall_o     (fall),
    .start_o    (start)
  );

  adc_conv_timer #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .sample_i (sample_i),
    .busy_o   (busy),
    .result_o (result)
  );

  adc_bus_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .strobe_q_i (strobe_q),
    .fall_i     (fall),
    .hben_i     (hben_i),
    .rom_mode_i (rom_mode_i),
    .result_i   (result),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  assign busy_no_o = ~busy;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni_i,
  input logic              rd_ni_i,
  input logic              hben_i,
  input logic              rom_mode_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              busy_no_o
);
  localparam int LW = $clog2(CONV_CYCLES + 2) + 1;
  localparam int HI_W = DATA_W - BYTE_W;

  logic          strb, strb_d;
  logic [LW-1:0] lo_cnt;

  assign strb = ~cs_ni_i & ~rd_ni_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_d <= 1'b0;
      lo_cnt <= '0;
    end else begin
      strb_d <= strb;
      lo_cnt <= busy_no_o ? '0 : lo_cnt + 1'b1;
    end
  end

  p_busy_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no_o) |-> lo_cnt == LW'(CONV_CYCLES));

  p_start_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no_o) |-> $past(strb && !strb_d && !hben_i));

  p_no_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no_o |-> lo_cnt < LW'(CONV_CYCLES));

  p_hi_nibble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && hben_i) |->
      (data_o[BYTE_W-1:HI_W] == '0) && (data_o[HI_W-1:0] == data_o[DATA_W-1:BYTE_W]));

  p_rom_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_mode_i && data_oe_o && $past(data_oe_o) && $stable(hben_i) && $stable(rom_mode_i))
      |-> $stable(data_o));
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni_i    (cs_ni_i),
  .rd_ni_i    (rd_ni_i),
  .hben_i     (hben_i),
  .rom_mode_i (rom_mode_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .busy_no_o  (busy_no_o)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;
  localparam int N = 8;
  localparam int SEL_DATA = 0, SEL_BUSY = 1, SEL_OE = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, rd_ni = 1'b1, hben = 1'b0, rom = 1'b0;
  logic [11:0] sample = '0;
  logic [11:0] data;
  logic oe, busy_n;

  always #10 clk = ~clk;

  adc_bus_ctrl #(.DATA_W(12), .BYTE_W(8), .CONV_CYCLES(N)) u_adc_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni_i(cs_ni), .rd_ni_i(rd_ni),
    .hben_i(hben), .rom_mode_i(rom), .sample_i(sample),
    .data_o(data), .data_oe_o(oe), .busy_no_o(busy_n)
  );

  typedef struct {
    string       tag;
    int          sel;
    logic [11:0] exp;
  } item_t;

  item_t q[$];
  event  ev;
  int    total = 0, fails = 0;
  bit    done = 1'b0;

  task automatic expect_val(input string tag, input int sel, input logic [11:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
    -> ev;
    #1;
  endtask

  task automatic compare_front();
    item_t it;
    logic [11:0] act;
    it = q.pop_front();
    case (it.sel)
      SEL_DATA: act = data;
      SEL_BUSY: act = {11'b0, busy_n};
      default:  act = {11'b0, oe};
    endcase
    total++;
    if (act !== it.exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(ev);
      while (q.size() > 0) compare_front();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic strobe(input logic on);
    cs_ni = ~on; rd_ni = ~on;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    cyc(2);
    expect_val("R1 busy at reset", SEL_BUSY, 12'h1);
    expect_val("R1 oe at reset", SEL_OE, 12'h0);
    rst_ni = 1'b1;
    cyc(1);

    // slow-memory parallel read spanning the conversion
    sample = 12'hA5C;
    strobe(1'b1);
    expect_val("R5 oe on strobe", SEL_OE, 12'h1);
    expect_val("R1 reset result", SEL_DATA, 12'h000);
    cyc(1);
    expect_val("R2 busy low after start", SEL_BUSY, 12'h0);
    cyc(N - 1);
    expect_val("R2 busy low last cycle", SEL_BUSY, 12'h0);
    expect_val("R8 old data during conv", SEL_DATA, 12'h000);
    cyc(1);
    expect_val("R2 busy high after N", SEL_BUSY, 12'h1);
    expect_val("R4 R8 new data at busy rise", SEL_DATA, 12'hA5C);
    cyc(3);
    expect_val("R10 held strobe no restart", SEL_BUSY, 12'h1);
    strobe(1'b0);
    expect_val("R5 oe off", SEL_OE, 12'h0);
    cs_ni = 1'b0; #1;
    expect_val("R5 cs only no oe", SEL_OE, 12'h0);
    cs_ni = 1'b1;
    cyc(1);

    // high-nibble read
    hben = 1'b1;
    strobe(1'b1);
    expect_val("R7 nibble view", SEL_DATA, 12'hA0A);
    cyc(2);
    expect_val("R7 no start on hben", SEL_BUSY, 12'h1);
    strobe(1'b0);
    hben = 1'b0;
    cyc(1);

    // strobe pulses during a conversion
    sample = 12'h3C7;
    strobe(1'b1);
    cyc(2); strobe(1'b0);
    cyc(2); strobe(1'b1);
    cyc(2); strobe(1'b0);
    cyc(2);
    expect_val("R3 busy still low", SEL_BUSY, 12'h0);
    cyc(1);
    expect_val("R3 ends on schedule", SEL_BUSY, 12'h1);
    cyc(3);
    expect_val("R3 no late start", SEL_BUSY, 12'h1);

    sample = 12'h111;
    strobe(1'b1);
    expect_val("R6 full word", SEL_DATA, 12'h3C7);
    cyc(1);
    strobe(1'b0);
    cyc(N + 2);

    // ROM mode
    rom = 1'b1;
    sample = 12'h8F2;
    strobe(1'b1);
    expect_val("R9 previous result", SEL_DATA, 12'h111);
    cyc(N + 1);
    expect_val("R9 busy done", SEL_BUSY, 12'h1);
    expect_val("R9 held through completion", SEL_DATA, 12'h111);
    strobe(1'b0);
    cyc(1);
    hben = 1'b1;
    strobe(1'b1);
    expect_val("R7 R4 nibble of new result", SEL_DATA, 12'h808);
    cyc(1);
    expect_val("R7 no start in rom", SEL_BUSY, 12'h1);
    strobe(1'b0);
    hben = 1'b0;
    cyc(1);
    sample = 12'hFFF;
    strobe(1'b1);
    expect_val("R9 R6 read shows stored", SEL_DATA, 12'h8F2);
    cyc(1);
    expect_val("R2 rom read starts", SEL_BUSY, 12'h0);
    strobe(1'b0);
    cyc(N + 2);
    expect_val("R4 rom conv done", SEL_BUSY, 12'h1);

    #1;
    while (q.size() > 0) compare_front();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule